// File: doc/BRIEF.md
# Asynchronous DRAM access sequencer

This block sits between a simple single-request port and a 256K x 1 asynchronous dynamic RAM with a multiplexed address bus. A request holds a two-bit operation code, an 18-bit word address and one write data bit. Once accepted, the block drives the row half of the address, pulls the row strobe low, switches the bus to the column half and then pulls the column strobe low. It then completes a plain read, an early write or a read-modify-write before it releases both strobes and waits out the precharge. Only one access is in flight at a time.

All device limits are parameters in nanoseconds, together with the clock period. Each limit is rounded up to whole clock cycles at elaboration time, so a slower or faster device grade, or a different clock, only needs new parameter values. Every strobe, the address bus and the data-in pin come straight from flops, so they carry no decode glitches.

Top module: `dram_seq`

## Requirements
- R1: While reset is high and in the cycle after it falls, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the precharge of that access has ended, and no strobe is low while `req_ready` is 1.
- R3: The row, address bits [17:9], is on `dram_addr` for at least one cycle before `dram_ras_n` falls and stays there for at least ceil(T_RAH_NS/CLK_NS) cycles after it (3 at defaults).
- R4: The column, address bits [8:0], is on `dram_addr` when `dram_cas_n` falls and does not change while `dram_cas_n` is low.
- R5: The number of cycles from the fall of `dram_ras_n` to the fall of `dram_cas_n` is at least ceil(25 ns / period) and at most ceil(60 ns / period). These are 5 and 12 at defaults.
- R6: `dram_ras_n` stays low for at least ceil(120 ns / period) cycles and for fewer than ceil(10000 ns / period). `dram_cas_n` stays low for at least ceil(60 ns / period) cycles. Both strobes rise on the same edge.
- R7: `dram_ras_n` stays high for at least ceil(100 ns / period) cycles between accesses, and one RAS fall is at least ceil(230 ns / period) cycles after the previous one.
- R8: The operation code is decoded as follows: `req_op[1]`=1 selects read-modify-write, `req_op`=01 selects write, and 00 selects read. On a read, `dram_we_n` stays 1. `dram_dout` is sampled one clock after the later of two points: the CAS access count (ceil(T_CAC_NS/period) after CAS fall) and the RAS access count (ceil(T_RAC_NS/period) after RAS fall). The sampled value appears on `rsp_rdata` with a one-cycle `rsp_valid` pulse.
- R9: On an early write, `dram_we_n` is low and `dram_din` equals the request's data at least ceil(T_WCS_NS/period) cycles before `dram_cas_n` falls (at least 1). Both hold until the strobes rise. A write produces no `rsp_valid` pulse.
- R10: On a read-modify-write, the read half behaves as in R8 with `dram_we_n` high. On the sample edge, `dram_we_n` falls with the new data on `dram_din`, while both strobes stay low. `dram_we_n` then stays low for at least ceil(T_WP_NS/period) cycles before the strobes rise. The response carries the old value.
- R11: `dram_cas_n` and `dram_we_n` are never low while `dram_ras_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| req_op | input | 2 | Operation code (see R8) |
| req_addr | input | 18 | Word address, row in the upper half |
| req_wdata | input | 1 | Bit to write |
| rsp_valid | output | 1 | One-cycle strobe with read data |
| rsp_rdata | output | 1 | Data read from the device |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_din | output | 1 | Data to the device |
| dram_dout | input | 1 | Data from the device |

## Verification
A state machine stuck or skipping a phase shows up within one access as a strobe width or RAS-to-CAS gap outside its window, or as a column strobe without a row strobe. A phase counter compared against the wrong limit shifts the data sample. The bench device model returns the inverted bit until the access time has passed, so a sample taken even one cycle early gives a wrong `rsp_rdata` on that same access. A wrong address mux select or a wrong data latch shows on the bus at the next strobe edge, or in the model's stored bit when it is read back later.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_RHOLD,
        ST_COL,
        ST_CAS,
        ST_RMW_WR,
        ST_PRE
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_READ,
        OP_WRITE,
        OP_RMW
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     wdata;
    } req_info_t;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic din;
    } pin_t;

    function automatic int ns2cyc(input int ns, input int per);
        return (ns + per - 1) / per;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic op_kind_e decode_op(input logic [1:0] op);
        if (op[1])      return OP_RMW;
        else if (op[0]) return OP_WRITE;
        else            return OP_READ;
    endfunction

    function automatic logic strobes_low(input seq_state_e s);
        return (s == ST_RHOLD) || (s == ST_COL) || (s == ST_CAS) || (s == ST_RMW_WR);
    endfunction

    function automatic pin_t pins_for(input seq_state_e s, input op_kind_e k, input logic wd);
        pin_t p;
        p = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, din: 1'b0};
        p.ras_n = !strobes_low(s);
        case (s)
            ST_COL: begin
                if (k == OP_WRITE) begin
                    p.we_n = 1'b0;
                    p.din  = wd;
                end
            end
            ST_CAS: begin
                p.cas_n = 1'b0;
                if (k == OP_WRITE) begin
                    p.we_n = 1'b0;
                    p.din  = wd;
                end
            end
            ST_RMW_WR: begin
                p.cas_n = 1'b0;
                p.we_n  = 1'b0;
                p.din   = wd;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/dram_seq_timer.sv
module dram_seq_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    // Cycles spent in the current phase; saturates so a long idle cannot wrap.
    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (cnt != {CNT_W{1'b1}})
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dram_seq_amux.sv
module dram_seq_amux #(
    parameter int ROW_W = 9,
    parameter int COL_W = 9,
    localparam int ADDR_W = ROW_W + COL_W,
    localparam int BUS_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              use_col,
    output logic [BUS_W-1:0]  bus
);
    logic [BUS_W-1:0] row_ext;
    logic [BUS_W-1:0] col_ext;

    assign row_ext = BUS_W'(addr[ADDR_W-1:COL_W]);
    assign col_ext = BUS_W'(addr[COL_W-1:0]);
    assign bus     = use_col ? col_ext : row_ext;
endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
    import dram_seq_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int ROW_C  = 1,
    parameter int RAH_C  = 3,
    parameter int LEAD_C = 2,
    parameter int CL_C   = 20,
    parameter int SAMP_C = 19,
    parameter int WPH_C  = 8,
    parameter int PRE_C  = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  op_kind_e         kind,
    input  logic [CNT_W-1:0] cnt,
    output seq_state_e       state_q,
    output seq_state_e       state_d,
    output logic             step,
    output logic             sample
);
    localparam logic [CNT_W-1:0] ROW_END  = CNT_W'(ROW_C - 1);
    localparam logic [CNT_W-1:0] RAH_END  = CNT_W'(RAH_C - 1);
    localparam logic [CNT_W-1:0] LEAD_END = CNT_W'(LEAD_C - 1);
    localparam logic [CNT_W-1:0] CL_END   = CNT_W'(CL_C - 1);
    localparam logic [CNT_W-1:0] SAMP_AT  = CNT_W'(SAMP_C);
    localparam logic [CNT_W-1:0] WPH_END  = CNT_W'(WPH_C - 1);
    localparam logic [CNT_W-1:0] PRE_END  = CNT_W'(PRE_C - 1);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (fire) state_d = ST_ROW;
            ST_ROW:    if (cnt == ROW_END) state_d = ST_RHOLD;
            ST_RHOLD:  if (cnt == RAH_END) state_d = ST_COL;
            ST_COL:    if (cnt == LEAD_END) state_d = ST_CAS;
            ST_CAS: begin
                if (kind == OP_RMW) begin
                    if (cnt == SAMP_AT) state_d = ST_RMW_WR;
                end else if (cnt == CL_END) begin
                    state_d = ST_PRE;
                end
            end
            ST_RMW_WR: if (cnt == WPH_END) state_d = ST_PRE;
            ST_PRE:    if (cnt == PRE_END) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign step   = (state_d != state_q);
    assign sample = (state_q == ST_CAS) && (kind != OP_WRITE) && (cnt == SAMP_AT);

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
    import dram_seq_pkg::*;
#(
    parameter int CLK_NS       = 5,
    parameter int ROW_W        = 9,
    parameter int COL_W        = 9,
    parameter int T_ASR_NS     = 0,
    parameter int T_RAH_NS     = 15,
    parameter int T_RCD_MIN_NS = 25,
    parameter int T_RAS_MIN_NS = 120,
    parameter int T_RP_NS      = 100,
    parameter int T_CAS_NS     = 60,
    parameter int T_RSH_NS     = 60,
    parameter int T_CAC_NS     = 60,
    parameter int T_RAC_NS     = 120,
    parameter int T_WCS_NS     = 5,
    parameter int T_DS_NS      = 0,
    parameter int T_DH_NS      = 30,
    parameter int T_WCH_NS     = 40,
    parameter int T_WP_NS      = 40,
    parameter int T_RWL_NS     = 40,
    parameter int T_RC_NS      = 230,
    localparam int ADDR_W      = ROW_W + COL_W,
    localparam int BUS_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wdata,
    output logic              rsp_valid,
    output logic              rsp_rdata,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic [BUS_W-1:0]  dram_addr,
    output logic              dram_din,
    input  logic              dram_dout
);
    // Phase lengths in cycles, rounded up from the nanosecond limits.
    localparam int ROW_C   = imax(1, ns2cyc(T_ASR_NS, CLK_NS));
    localparam int RAH_C   = imax(1, ns2cyc(T_RAH_NS, CLK_NS));
    localparam int RCDN_C  = ns2cyc(T_RCD_MIN_NS, CLK_NS);
    localparam int LEAD_C  = imax(imax(1, ns2cyc(T_WCS_NS, CLK_NS)),
                                  imax(ns2cyc(T_DS_NS, CLK_NS), RCDN_C - RAH_C));
    localparam int RCD_C   = RAH_C + LEAD_C;
    localparam int SAMP_C  = imax(ns2cyc(T_CAC_NS, CLK_NS), ns2cyc(T_RAC_NS, CLK_NS) - RCD_C);
    localparam int CL_C    = imax(imax(imax(ns2cyc(T_CAS_NS, CLK_NS), ns2cyc(T_RSH_NS, CLK_NS)),
                                       imax(ns2cyc(T_RAS_MIN_NS, CLK_NS) - RCD_C, SAMP_C + 1)),
                                  imax(ns2cyc(T_DH_NS, CLK_NS), ns2cyc(T_WCH_NS, CLK_NS)));
    localparam int WPH_C   = imax(imax(imax(1, ns2cyc(T_WP_NS, CLK_NS)),
                                       imax(ns2cyc(T_WCH_NS, CLK_NS), ns2cyc(T_DH_NS, CLK_NS))),
                                  imax(ns2cyc(T_RWL_NS, CLK_NS),
                                       ns2cyc(T_RAS_MIN_NS, CLK_NS) - RCD_C - SAMP_C - 1));
    localparam int PRE_C   = imax(imax(1, ns2cyc(T_RP_NS, CLK_NS)),
                                  ns2cyc(T_RC_NS, CLK_NS) - RCD_C - CL_C - 1 - ROW_C);
    localparam int LONGEST = imax(imax(imax(ROW_C, RAH_C), imax(LEAD_C, CL_C)),
                                  imax(imax(SAMP_C + 1, WPH_C), PRE_C));
    localparam int CNT_W   = $clog2(LONGEST + 2);

    seq_state_e        state_q;
    seq_state_e        state_d;
    logic              step;
    logic              sample;
    logic              fire;
    logic [CNT_W-1:0]  cnt;

    req_info_t         info_q;
    req_info_t         info_d;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_d;
    pin_t              pins_q;
    pin_t              pins_d;
    logic [BUS_W-1:0]  bus_d;
    logic [BUS_W-1:0]  bus_q;
    logic              use_col;
    logic              bus_load;
    logic              rsp_valid_q;
    logic              rsp_rdata_q;

    assign req_ready = (state_q == ST_IDLE);
    assign fire      = req_valid && req_ready && !rst;

    // Fields seen by the output decode on the accepting edge already.
    always_comb begin
        info_d = info_q;
        addr_d = addr_q;
        if (fire) begin
            info_d.kind  = decode_op(req_op);
            info_d.wdata = req_wdata;
            addr_d       = req_addr;
        end
    end

    dram_seq_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk (clk),
        .rst (rst),
        .clr (step),
        .cnt (cnt)
    );

    dram_seq_ctrl #(
        .CNT_W  (CNT_W),
        .ROW_C  (ROW_C),
        .RAH_C  (RAH_C),
        .LEAD_C (LEAD_C),
        .CL_C   (CL_C),
        .SAMP_C (SAMP_C),
        .WPH_C  (WPH_C),
        .PRE_C  (PRE_C)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .kind    (info_q.kind),
        .cnt     (cnt),
        .state_q (state_q),
        .state_d (state_d),
        .step    (step),
        .sample  (sample)
    );

    assign use_col  = (state_d == ST_COL) || (state_d == ST_CAS) || (state_d == ST_RMW_WR);
    assign bus_load = use_col || (state_d == ST_ROW) || (state_d == ST_RHOLD);

    dram_seq_amux #(
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) u_amux (
        .addr    (addr_d),
        .use_col (use_col),
        .bus     (bus_d)
    );

    assign pins_d = pins_for(state_d, info_d.kind, info_d.wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            info_q      <= '{kind: OP_READ, wdata: 1'b0};
            addr_q      <= '0;
            pins_q      <= '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, din: 1'b0};
            bus_q       <= '0;
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= 1'b0;
        end else begin
            info_q      <= info_d;
            addr_q      <= addr_d;
            pins_q      <= pins_d;
            if (bus_load)
                bus_q <= bus_d;
            rsp_valid_q <= sample;
            if (sample)
                rsp_rdata_q <= dram_dout;
        end
    end

    assign dram_ras_n = pins_q.ras_n;
    assign dram_cas_n = pins_q.cas_n;
    assign dram_we_n  = pins_q.we_n;
    assign dram_din   = pins_q.din;
    assign dram_addr  = bus_q;
    assign rsp_valid  = rsp_valid_q;
    assign rsp_rdata  = rsp_rdata_q;
endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk #(
    parameter int CLK_NS       = 5,
    parameter int BUS_W        = 9,
    parameter int T_RCD_MIN_NS = 25,
    parameter int T_RCD_MAX_NS = 60,
    parameter int T_RAS_MIN_NS = 120,
    parameter int T_RAS_MAX_NS = 10000,
    parameter int T_RP_NS      = 100
) (
    input logic             clk,
    input logic             rst,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic [BUS_W-1:0] dram_addr,
    input logic             req_ready,
    input logic             rsp_valid
);
    localparam int RCDN_C = (T_RCD_MIN_NS + CLK_NS - 1) / CLK_NS;
    localparam int RCDX_C = (T_RCD_MAX_NS + CLK_NS - 1) / CLK_NS;
    localparam int RASN_C = (T_RAS_MIN_NS + CLK_NS - 1) / CLK_NS;
    localparam int RASX_C = (T_RAS_MAX_NS + CLK_NS - 1) / CLK_NS;
    localparam int RP_C   = (T_RP_NS + CLK_NS - 1) / CLK_NS;

    logic [15:0] low_cnt;
    logic [15:0] high_cnt;
    logic [15:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt  <= '0;
            high_cnt <= 16'hffff;
            gap_cnt  <= '0;
        end else begin
            low_cnt  <= ras_n ? 16'd0 : ((low_cnt == 16'hffff) ? low_cnt : low_cnt + 16'd1);
            high_cnt <= !ras_n ? 16'd0 : ((high_cnt == 16'hffff) ? high_cnt : high_cnt + 16'd1);
            gap_cnt  <= (ras_n || !cas_n) ? 16'd0 : gap_cnt + 16'd1;
        end
    end

    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (rst) !cas_n |-> !ras_n); // R11
    AST_WE_UNDER_RAS: assert property (@(posedge clk) disable iff (rst) !we_n |-> !ras_n); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) req_ready |-> (ras_n && cas_n && we_n)); // R2
    AST_EARLY_WE: assert property (@(posedge clk) disable iff (rst) ($fell(cas_n) && !we_n) |-> $past(!we_n)); // R9
    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst) $fell(ras_n) |=> $stable(dram_addr)); // R3
    AST_COL_HOLD: assert property (@(posedge clk) disable iff (rst) (!cas_n && $past(!cas_n)) |-> $stable(dram_addr)); // R4
    AST_JOINT_RISE: assert property (@(posedge clk) disable iff (rst) $rose(ras_n) |-> $rose(cas_n)); // R6
    AST_RAS_MIN: assert property (@(posedge clk) disable iff (rst) $rose(ras_n) |-> (low_cnt >= 16'(RASN_C))); // R6
    AST_RAS_MAX: assert property (@(posedge clk) disable iff (rst) !ras_n |-> (low_cnt < 16'(RASX_C))); // R6
    AST_PRECHARGE: assert property (@(posedge clk) disable iff (rst) $fell(ras_n) |-> (high_cnt >= 16'(RP_C))); // R7
    AST_RCD_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> ((gap_cnt >= 16'(RCDN_C)) && (gap_cnt <= 16'(RCDX_C)))); // R5
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst) rsp_valid |=> !rsp_valid); // R8
    AST_RSP_IN_CAS: assert property (@(posedge clk) disable iff (rst) rsp_valid |-> $past(!cas_n)); // R8
endmodule

bind dram_seq dram_seq_chk #(
    .CLK_NS       (CLK_NS),
    .BUS_W        (BUS_W),
    .T_RCD_MIN_NS (T_RCD_MIN_NS),
    .T_RAS_MIN_NS (T_RAS_MIN_NS),
    .T_RP_NS      (T_RP_NS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .dram_addr (dram_addr),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid)
);

// File: tb/dram_seq_tb.sv
module dram_seq_tb;
    // Bench-side cycle limits at a 5 ns clock.
    function automatic int cdiv(input int ns);
        return (ns + 4) / 5;
    endfunction
    localparam int B_RAH  = cdiv(15);
    localparam int B_RCDN = cdiv(25);
    localparam int B_RCDX = cdiv(60);
    localparam int B_RAS  = cdiv(120);
    localparam int B_CAS  = cdiv(60);
    localparam int B_RP   = cdiv(100);
    localparam int B_RC   = cdiv(230);
    localparam int B_CAC  = cdiv(60);
    localparam int B_RAC  = cdiv(120);
    localparam int B_WP   = cdiv(40);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'b00;
    logic [17:0] req_addr = '0;
    logic        req_wdata = 1'b0;
    logic        rsp_valid;
    logic        rsp_rdata;
    logic        dram_ras_n;
    logic        dram_cas_n;
    logic        dram_we_n;
    logic [8:0]  dram_addr;
    logic        dram_din;
    logic        dram_dout = 1'b0;

    always #2.5 clk = ~clk;

    dram_seq u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_addr(dram_addr),
        .dram_din(dram_din), .dram_dout(dram_dout)
    );

    int total = 0;
    int bad = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    bit ref_mem [int];
    bit dev_mem [int];

    function automatic bit rd_ref(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : 1'b0;
    endfunction
    function automatic bit rd_dev(input int a);
        return dev_mem.exists(a) ? dev_mem[a] : 1'b0;
    endfunction

    // 0 read, 1 write, 2 read-modify-write
    int          cur_kind = 0;
    logic [17:0] cur_addr = '0;
    logic        cur_wd = 1'b0;
    int          rsp_cnt = 0;
    logic        rsp_val = 1'b0;

    // Device model and pin monitor, sampled on the falling edge.
    int          cyc = 0;
    int          last_fall = 0, last_rise = 0, last_cas = 0;
    bit          have_fall = 0, have_rise = 0;
    logic        p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
    logic [8:0]  p_addr = '0;
    logic [8:0]  row_l = '0, col_l = '0;
    bit          col_moved = 0, addr_moved = 0, we_seen = 0;
    int          we_len = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (rsp_valid) begin
                rsp_cnt++;
                rsp_val = rsp_rdata;
            end
            if (!dram_cas_n && dram_ras_n) check(0, "R11 cas low with ras high", 1, 0);
            if (!dram_we_n && dram_ras_n) check(0, "R11 we low with ras high", 1, 0);
            if (!dram_ras_n && p_ras) begin
                check(dram_addr == cur_addr[17:9], "R3 row at ras fall", dram_addr, cur_addr[17:9]);
                check(p_addr == cur_addr[17:9], "R3 row setup", p_addr, cur_addr[17:9]);
                if (have_fall) check(cyc - last_fall >= B_RC, "R7 cycle time", cyc - last_fall, B_RC);
                if (have_rise) check(cyc - last_rise >= B_RP, "R7 precharge", cyc - last_rise, B_RP);
                last_fall = cyc; have_fall = 1; row_l = dram_addr;
                col_moved = 0; addr_moved = 0; we_seen = 0; we_len = 0;
            end
            if (!dram_ras_n && !p_ras && dram_cas_n && !col_moved && dram_addr != p_addr) begin
                col_moved = 1;
                check(cyc - last_fall >= B_RAH, "R3 row hold", cyc - last_fall, B_RAH);
            end
            if (!dram_we_n) begin
                we_seen = 1;
                we_len++;
            end
            if (!dram_cas_n && p_cas) begin
                check((cyc - last_fall >= B_RCDN) && (cyc - last_fall <= B_RCDX),
                      "R5 ras to cas", cyc - last_fall, B_RCDN);
                check(dram_addr == cur_addr[8:0], "R4 column at cas fall", dram_addr, cur_addr[8:0]);
                col_l = dram_addr; last_cas = cyc;
                if (cur_kind == 1) begin
                    check(!p_we && !dram_we_n && dram_din == cur_wd, "R9 early write setup",
                          {p_we, dram_din}, {1'b0, cur_wd});
                    dev_mem[int'({row_l, col_l})] = dram_din;
                end else begin
                    check(dram_we_n, "R8 we high at cas fall", dram_we_n, 1);
                end
            end
            if (!dram_cas_n && !p_cas && dram_addr != p_addr) addr_moved = 1;
            if (!dram_we_n && p_we && !dram_cas_n && !p_cas) begin
                check(cur_kind == 2 && dram_din == cur_wd && rsp_cnt == 1, "R10 we fall after sample",
                      rsp_cnt, 1);
                dev_mem[int'({row_l, col_l})] = dram_din;
            end
            if (dram_ras_n && !p_ras) begin
                check(cyc - last_fall >= B_RAS, "R6 ras low width", cyc - last_fall, B_RAS);
                check(cyc - last_cas >= B_CAS, "R6 cas low width", cyc - last_cas, B_CAS);
                check(dram_cas_n && !p_cas, "R6 joint release", dram_cas_n, 1);
                check(!addr_moved, "R4 column held", addr_moved, 0);
                if (cur_kind == 0) check(!we_seen, "R8 we stays high", we_seen, 0);
                if (cur_kind == 2) check(we_len >= B_WP, "R10 we pulse width", we_len, B_WP);
                last_rise = cyc; have_rise = 1;
            end
            // Data is valid only once both access times have passed; else inverted.
            if (!dram_cas_n) begin
                if ((cyc - last_cas >= B_CAC) && (cyc - last_fall >= B_RAC))
                    dram_dout = rd_dev(int'({row_l, col_l}));
                else
                    dram_dout = ~rd_dev(int'({row_l, col_l}));
            end else begin
                dram_dout = 1'b0;
            end
        end
        p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n; p_addr = dram_addr;
    end

    function automatic int kind_of(input logic [1:0] op);
        if (op[1]) return 2;
        if (op[0]) return 1;
        return 0;
    endfunction

    task automatic run(input logic [1:0] op, input logic [17:0] a, input logic wd);
        bit old;
        cur_kind = kind_of(op); cur_addr = a; cur_wd = wd; rsp_cnt = 0;
        old = rd_ref(int'(a));
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R2 busy after accept", req_ready, 0);
        while (!req_ready) @(negedge clk);
        if (cur_kind == 1) begin
            check(rsp_cnt == 0, "R9 no response on write", rsp_cnt, 0);
            check(rd_dev(int'(a)) == wd, "R9 bit stored", rd_dev(int'(a)), wd);
            ref_mem[int'(a)] = wd;
        end else begin
            check(rsp_cnt == 1, "R8 one response pulse", rsp_cnt, 1);
            check(rsp_val == old, cur_kind == 2 ? "R10 old data returned" : "R8 read data",
                  rsp_val, old);
            if (cur_kind == 2) begin
                check(rd_dev(int'(a)) == wd, "R10 new bit stored", rd_dev(int'(a)), wd);
                ref_mem[int'(a)] = wd;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [17:0] pool [8];
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(dram_ras_n && dram_cas_n && dram_we_n && !rsp_valid && req_ready,
              "R1 state in reset", {dram_ras_n, dram_cas_n, dram_we_n, rsp_valid, req_ready}, 5'b11101);
        rst = 1'b0;
        @(negedge clk);
        check(dram_ras_n && dram_cas_n && dram_we_n && !rsp_valid && req_ready,
              "R1 state after reset", {dram_ras_n, dram_cas_n, dram_we_n, rsp_valid, req_ready}, 5'b11101);

        // Directed corners: address extremes, write then read, RMW, op code 11.
        run(2'b01, 18'h00000, 1'b1);
        run(2'b01, 18'h3FFFF, 1'b1);
        run(2'b00, 18'h00000, 1'b0);
        run(2'b00, 18'h3FFFF, 1'b0);
        run(2'b10, 18'h3FFFF, 1'b0);
        run(2'b00, 18'h3FFFF, 1'b0);
        run(2'b11, 18'h3FFFF, 1'b1);
        run(2'b00, 18'h3FE00, 1'b0);
        run(2'b00, 18'h001FF, 1'b0);

        for (int i = 0; i < 8; i++) pool[i] = 18'($urandom());
        for (int i = 0; i < 60; i++) begin
            logic [1:0] op;
            op = 2'($urandom_range(0, 3));
            run(op, pool[$urandom_range(0, 7)], 1'($urandom()));
        end

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule